// File: doc/BRIEF.md
# Function-Code Integer Execution Unit

This unit carries out the arithmetic and logic step of register-register instructions in a small 32-bit integer core. It has no clock. The core supplies two register operands, a 5-bit shift count and the 6-bit function code from the low end of the instruction word. The unit returns a result and a flag that shows whether the code named a supported operation.

The supported codes do not form a contiguous range. Every code outside that set gives a zero result with the flag low, so the core can treat it as an illegal operation. A separate equality output compares the two operands whatever the function code is, and the core uses it to resolve branch-if-equal. Apart from the result, no operation changes any state.

Inside the top, a control decoder turns the function code into a one-hot group of operation strobes. A datapath computes every candidate result and merges them under those strobes.

Top module: `fcode_exu`

## Requirements
- R1: Function code 32 (6'b100000) gives opA + opB modulo 2^32, with no overflow indication.
- R2: Function code 34 (6'b100010) gives opA − opB modulo 2^32, that is the first operand minus the second.
- R3: Function code 24 (6'b011000) gives the low 32 bits of the product opA × opB.
- R4: Function code 4 (6'b000100) gives the bitwise AND of opA and opB.
- R5: Function code 2 (6'b000010) gives opB shifted left by shAmt, with zeros filling the low bits. opA has no effect on the result.
- R6: Function code 3 (6'b000011) gives opB shifted right by shAmt, with zeros filling the high bits (logical shift). opA has no effect on the result.
- R7: Function code 5 (6'b000101) gives the one's complement ~opB. opA has no effect on the result.
- R8: For the seven codes above, opValid is 1. For any other code, opValid is 0 and result is all zeros.
- R9: isEqual is 1 exactly when opA equals opB, whatever the function code is.
- R10: shAmt affects only codes 2 and 3. Under every other code, changing shAmt leaves result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First source operand |
| opB | input | 32 | Second source operand |
| shAmt | input | 5 | Shift count from instruction bits 10:6 |
| funct | input | 6 | Function code from instruction bits 5:0 |
| result | output | 32 | Result of the selected operation |
| opValid | output | 1 | High when funct is a supported code |
| isEqual | output | 1 | High when opA equals opB |

## Verification
The bench tries all 64 function codes against each operand pattern. A decoder that accepted a neighbouring code such as 33 or 35, or that leaked a stale result on an unsupported code, would show a nonzero result or a raised flag. The corner operands are:
- all-ones and sign-bit operands, where a missing wrap or a widened product would spill past 32 bits;
- shifts by 0 and by 31 of a negative value, where an arithmetic right shift would smear the sign bit;
- complement and shift cases with opA swept, which expose a datapath that wrongly mixes in the first operand;
- equal and unequal operand pairs under invalid codes, which catch an equality output wrongly gated by the decoder.

// File: rtl/fcode_exu_pkg.sv
package fcode_exu_pkg;

  localparam int FUNCT_W = 6;
  localparam int NUM_OPS = 7;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'd34;
  localparam logic [FUNCT_W-1:0] FN_MUL = 6'd24;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'd4;
  localparam logic [FUNCT_W-1:0] FN_SLL = 6'd2;
  localparam logic [FUNCT_W-1:0] FN_SRL = 6'd3;
  localparam logic [FUNCT_W-1:0] FN_NOT = 6'd5;

  // Strobes from the decoder to the datapath. Packed order fixes the
  // vector index used by the datapath merge: opAdd is bit 6, opNot bit 0.
  typedef struct packed {
    logic opAdd;
    logic opSub;
    logic opMul;
    logic opAnd;
    logic opSll;
    logic opSrl;
    logic opNot;
  } exuSel_t;

  localparam int IDX_ADD = 6;
  localparam int IDX_SUB = 5;
  localparam int IDX_MUL = 4;
  localparam int IDX_AND = 3;
  localparam int IDX_SLL = 2;
  localparam int IDX_SRL = 1;
  localparam int IDX_NOT = 0;

endpackage

// File: rtl/fcode_exu_ctrl.sv
module fcode_exu_ctrl
  import fcode_exu_pkg::*;
(
  input  logic [FUNCT_W-1:0] funct,
  output exuSel_t            sel,
  output logic               opValid
);

  always_comb begin
    sel = '0;
    case (funct)
      FN_ADD:  sel.opAdd = 1'b1;
      FN_SUB:  sel.opSub = 1'b1;
      FN_MUL:  sel.opMul = 1'b1;
      FN_AND:  sel.opAnd = 1'b1;
      FN_SLL:  sel.opSll = 1'b1;
      FN_SRL:  sel.opSrl = 1'b1;
      FN_NOT:  sel.opNot = 1'b1;
      default: sel = '0;
    endcase
  end

  assign opValid = |sel;

  // R8: at most one strobe may be active for any code
  always_comb begin
    a_r8_sel_onehot: assert ($onehot0(sel))
      else $error("a_r8_sel_onehot: several strobes active");
  end

endmodule

// File: rtl/fcode_exu_dp.sv
module fcode_exu_dp
  import fcode_exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SH_W-1:0]   shAmt,
  input  exuSel_t           sel,
  output logic [DATA_W-1:0] result,
  output logic              isEqual
);

  logic [NUM_OPS-1:0] selVec;
  logic [DATA_W-1:0]  opRes [NUM_OPS];
  logic [DATA_W-1:0]  mergeChain [NUM_OPS+1];
  logic [2*DATA_W-1:0] fullProd;

  assign selVec   = sel;
  assign fullProd = opA * opB;

  assign opRes[IDX_ADD] = opA + opB;
  assign opRes[IDX_SUB] = opA - opB;
  assign opRes[IDX_MUL] = fullProd[DATA_W-1:0];
  assign opRes[IDX_AND] = opA & opB;
  assign opRes[IDX_SLL] = opB << shAmt;
  assign opRes[IDX_SRL] = opB >> shAmt;
  assign opRes[IDX_NOT] = ~opB;

  // AND-OR merge; an all-zero strobe vector yields zero
  assign mergeChain[0] = '0;
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_merge
    assign mergeChain[i+1] = mergeChain[i] | (opRes[i] & {DATA_W{selVec[i]}});
  end
  assign result = mergeChain[NUM_OPS];

  assign isEqual = (opA == opB);

  // R2 / R9: subtracting equal operands must give zero
  always_comb begin
    if (sel.opSub && isEqual)
      a_r2_sub_equal_zero: assert (result == '0)
        else $error("a_r2_sub_equal_zero: nonzero difference of equal operands");
  end

  // R6: a logical right shift by a nonzero count clears the top bit
  always_comb begin
    if (sel.opSrl && shAmt != '0)
      a_r6_srl_zero_fill: assert (result[DATA_W-1] == 1'b0)
        else $error("a_r6_srl_zero_fill: sign bit filled");
  end

endmodule

// File: rtl/fcode_exu.sv
module fcode_exu
  import fcode_exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [SH_W-1:0]    shAmt,
  input  logic [FUNCT_W-1:0] funct,
  output logic [DATA_W-1:0]  result,
  output logic               opValid,
  output logic               isEqual
);

  exuSel_t selBus;

  fcode_exu_ctrl u_ctrl (
    .funct   (funct),
    .sel     (selBus),
    .opValid (opValid)
  );

  fcode_exu_dp #(.DATA_W(DATA_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .shAmt   (shAmt),
    .sel     (selBus),
    .result  (result),
    .isEqual (isEqual)
  );

  // R8: an unrecognised code must produce a zero result
  always_comb begin
    if (!opValid)
      a_r8_invalid_zero: assert (result == '0)
        else $error("a_r8_invalid_zero: result not cleared");
  end

  // R7: the complement code must return ~opB at the port
  always_comb begin
    if (funct == FN_NOT)
      a_r7_cmpl_port: assert (result == ~opB && opValid)
        else $error("a_r7_cmpl_port: complement mismatch");
  end

  // R4: an AND result never has bits that opB lacks
  always_comb begin
    if (funct == FN_AND)
      a_r4_and_subset: assert ((result & ~opB) == '0)
        else $error("a_r4_and_subset: stray bits");
  end

endmodule

// File: tb/fcode_exu_bench.sv
module fcode_exu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA, opB, result;
  logic [4:0]  shAmt;
  logic [5:0]  funct;
  logic        opValid, isEqual;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fcode_exu u_fcode_exu (
    .opA(opA), .opB(opB), .shAmt(shAmt), .funct(funct),
    .result(result), .opValid(opValid), .isEqual(isEqual)
  );

  function automatic logic [31:0] refRes(input logic [5:0] f, input logic [31:0] a,
                                         input logic [31:0] b, input logic [4:0] s);
    logic [63:0] p;
    p = {32'd0, a} * {32'd0, b};
    case (f)
      6'd32: return a + b;
      6'd34: return a - b;
      6'd24: return p[31:0];
      6'd4:  return a & b;
      6'd2:  return b << s;
      6'd3:  return b >> s;
      6'd5:  return ~b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit refValid(input logic [5:0] f);
    return f == 6'd32 || f == 6'd34 || f == 6'd24 || f == 6'd4 ||
           f == 6'd2 || f == 6'd3 || f == 6'd5;
  endfunction

  function automatic string reqOf(input logic [5:0] f);
    case (f)
      6'd32: return "R1"; 6'd34: return "R2"; 6'd24: return "R3";
      6'd4:  return "R4"; 6'd2:  return "R5"; 6'd3:  return "R6";
      6'd5:  return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s funct=%0d a=%h b=%h s=%0d act=%h exp=%h",
               req, funct, opA, opB, shAmt, act, exp);
    end
  endtask

  // apply on falling edge, sample before next rising edge
  task automatic apply(input logic [5:0] f, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s);
    @(negedge clk);
    funct = f; opA = a; opB = b; shAmt = s;
    #1;
    checkVal(reqOf(f), result, refRes(f, a, b, s));
    checkVal("R8", {31'd0, opValid}, {31'd0, refValid(f)});
    checkVal("R9", {31'd0, isEqual}, {31'd0, a == b});
  endtask

  task automatic allCodes(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s);
    for (int f = 0; f < 64; f++) apply(6'(f), a, b, s);
  endtask

  initial begin
    int seed;
    logic [31:0] ra, rb, keep;
    logic [4:0]  rs;
    seed = 32'h1a2b3c;
    void'($urandom(seed));
    opA = '0; opB = '0; shAmt = '0; funct = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-like idle: all-zero inputs, code 0 unsupported (R8)
    #1;
    checkVal("R8", result, 32'd0);
    checkVal("R8", {31'd0, opValid}, 32'd0);
    checkVal("R9", {31'd0, isEqual}, 32'd1);

    // directed corners, every code each
    allCodes(32'hFFFF_FFFF, 32'h0000_0001, 5'd0);   // R1 wrap
    allCodes(32'h0000_0000, 32'h0000_0001, 5'd31);  // R2 borrow
    allCodes(32'h8000_0000, 32'h8000_0000, 5'd31);  // R6 logical, R9 equal
    allCodes(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1);   // R3 low word
    allCodes(32'h1234_5678, 32'hF0F0_0F0F, 5'd16);
    allCodes(32'h0000_0000, 32'hDEAD_BEEF, 5'd0);

    // R5 R6 R7: opA has no effect on shifts or complement
    for (int k = 0; k < 20; k++) begin
      rb = $urandom; rs = 5'($urandom);
      apply(6'd2, $urandom, rb, rs);
      apply(6'd3, $urandom, rb, rs);
      apply(6'd5, $urandom, rb, rs);
    end

    // R10: shAmt has no effect outside shift codes
    for (int k = 0; k < 10; k++) begin
      ra = $urandom; rb = $urandom;
      foreach (refResCodes[i]) begin
        apply(refResCodes[i], ra, rb, 5'd0);
        keep = result;
        apply(refResCodes[i], ra, rb, 5'($urandom | 1));
        checkVal("R10", result, keep);
      end
    end

    // random sweep over all codes
    for (int k = 0; k < 60; k++) begin
      ra = $urandom; rb = ($urandom % 4 == 0) ? ra : $urandom;
      allCodes(ra, rb, 5'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [5:0] refResCodes [5] = '{6'd32, 6'd34, 6'd24, 6'd4, 6'd5};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule